// File: doc/BRIEF.md
# Software Interrupt Pending Register

This block keeps a word of software-raised interrupt requests. Firmware changes it through three kinds of update: a bitwise set, a bitwise clear, and a plain overwrite. Each kind takes its operand from the low half of a 64-bit data word. The block works out the new value of the word. It stores that value and raises a one-cycle `changed_o` pulse only when the new word differs from the one already held.

The interrupt controller outside the block must scan the pending bits again whenever they move. The block therefore also raises a one-cycle `recheck_o` request. It does so only when the word has actually changed and interrupts were enabled in the cycle of the update. Writes that leave the word as it was cause no activity downstream.

The three update selects act as the input's valid strobes. The block accepts an update on every clock edge, so there is no ready signal and no back-pressure. The status outputs are plain pins with no handshake.

Top module: `sirq_pending_reg`

## Requirements
- R1: After reset, `pend_o` is 0 and `changed_o` and `recheck_o` are low.
- R2: A set update (`op_set` alone) ORs `wr_data[31:0]` into the stored word.
- R3: A clear update (`op_clr` alone) ANDs the stored word with the inverse of `wr_data[31:0]`.
- R4: A write update (`op_wr` alone) replaces the stored word with `wr_data[31:0]`.
- R5: Bits `wr_data[63:32]` have no effect on the stored word or on either pulse.
- R6: `changed_o` is high in the cycle after the clock edge that sampled an update if and only if that update altered the stored word. An update that leaves the word unchanged gives no pulse and the word stays stable.
- R7: `recheck_o` is high in the cycle after that edge if and only if the word changed and `irq_en` was high when the update was sampled.
- R8: When several selects are high in one cycle, the write is applied first, then the set, then the clear, all with the same operand. For example, write+clear gives 0 and set+clear gives old & ~operand.
- R9: Both pulses last one cycle. With no select high at an edge, both are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_set | input | 1 | Set update strobe |
| op_clr | input | 1 | Clear update strobe |
| op_wr | input | 1 | Overwrite update strobe |
| wr_data | input | 64 | Update operand; only the low 32 bits are used |
| irq_en | input | 1 | Interrupts-enabled flag, sampled with the update |
| pend_o | output | 32 | Current pending word |
| changed_o | output | 1 | One-cycle pulse: the word changed |
| recheck_o | output | 1 | One-cycle pulse: the controller must re-scan the pending bits |

## Verification
All three results are due exactly one clock edge after an update is sampled: the new word, the `changed_o` pulse and the `recheck_o` pulse. The pulses fall again on the next edge unless a further update alters the word. The bench drives each update on a falling edge and removes it on the next falling edge. It reads all outputs at that second falling edge, which is half a cycle after the edge that registered the update. For the one-cycle checks it reads them once more a full cycle later.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef struct packed {
    logic wr;
    logic set;
    logic clr;
  } sirq_op_t;
endpackage

// File: rtl/sirq_next_calc.sv
module sirq_next_calc
  import sirq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  sirq_op_t         op,
  input  logic [REG_W-1:0] cur,
  input  logic [REG_W-1:0] operand,
  output logic [REG_W-1:0] nxt
);
  // Per-bit composition: overwrite, then OR, then AND-NOT.
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    logic after_wr;
    logic after_set;
    always_comb begin
      after_wr  = op.wr  ? operand[b] : cur[b];
      after_set = op.set ? (after_wr | operand[b]) : after_wr;
      nxt[b]    = op.clr ? (after_set & ~operand[b]) : after_set;
    end
  end
endmodule

// File: rtl/sirq_change_detect.sv
module sirq_change_detect #(
  parameter int REG_W = 32
) (
  input  logic [REG_W-1:0] cur,
  input  logic [REG_W-1:0] nxt,
  output logic             differs
);
  logic [REG_W-1:0] delta;
  assign delta   = cur ^ nxt;
  assign differs = |delta;
endmodule

// File: rtl/sirq_state_reg.sv
module sirq_state_reg #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_op,
  input  logic             differs,
  input  logic             irq_en,
  input  logic [REG_W-1:0] nxt,
  output logic [REG_W-1:0] word_q,
  output logic             chg_q,
  output logic             rchk_q
);
  logic take;
  assign take = any_op & differs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      chg_q  <= 1'b0;
      rchk_q <= 1'b0;
    end else begin
      if (take) word_q <= nxt;
      chg_q  <= take;
      rchk_q <= take & irq_en;
    end
  end

  a_r9_pulse_needs_op: assert property (@(posedge clk) disable iff (!rst_n)
    !any_op |=> !chg_q && !rchk_q);
endmodule

// File: rtl/sirq_pending_reg.sv
module sirq_pending_reg
  import sirq_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_set,
  input  logic              op_clr,
  input  logic              op_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_en,
  output logic [REG_W-1:0]  pend_o,
  output logic              changed_o,
  output logic              recheck_o
);
  localparam int HI_W = DATA_W - REG_W;

  sirq_op_t         op;
  logic [REG_W-1:0] operand;
  logic [REG_W-1:0] nxt;
  logic             differs;
  logic             any_op;
  logic             unused_hi;

  assign op        = '{wr: op_wr, set: op_set, clr: op_clr};
  assign operand   = wr_data[REG_W-1:0];
  assign unused_hi = ^wr_data[DATA_W-1:DATA_W-HI_W];
  assign any_op    = op_set | op_clr | op_wr;

  sirq_next_calc #(.REG_W(REG_W)) u_next (
    .op(op), .cur(pend_o), .operand(operand), .nxt(nxt)
  );

  sirq_change_detect #(.REG_W(REG_W)) u_cmp (
    .cur(pend_o), .nxt(nxt), .differs(differs)
  );

  sirq_state_reg #(.REG_W(REG_W)) u_state (
    .clk(clk), .rst_n(rst_n), .any_op(any_op), .differs(differs),
    .irq_en(irq_en), .nxt(nxt), .word_q(pend_o), .chg_q(changed_o),
    .rchk_q(recheck_o)
  );

  a_r6_pulse_iff_moved: assert property (@(posedge clk) disable iff (!rst_n)
    changed_o == (pend_o != $past(pend_o)));
  a_r7_recheck_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    recheck_o |-> changed_o && $past(irq_en));
  a_r7_recheck_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    changed_o && $past(irq_en) |-> recheck_o);
  a_r4_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && !op_set && !op_clr) |=> pend_o == $past(wr_data[REG_W-1:0]));
  a_r2_set_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (op_set && !op_wr && !op_clr) |=> (pend_o & $past(pend_o)) == $past(pend_o));
  a_r3_clear_drops_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (op_clr && !op_wr && !op_set) |=> (pend_o & $past(wr_data[REG_W-1:0])) == '0);
endmodule

// File: tb/sirq_pending_reg_tb.sv
module sirq_pending_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_set = 1'b0, op_clr = 1'b0, op_wr = 1'b0;
  logic [63:0] wr_data = '0;
  logic        irq_en = 1'b0;
  logic [31:0] pend_o;
  logic        changed_o, recheck_o;
  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  sirq_pending_reg u_dut (
    .clk(clk), .rst_n(rst_n), .op_set(op_set), .op_clr(op_clr), .op_wr(op_wr),
    .wr_data(wr_data), .irq_en(irq_en), .pend_o(pend_o),
    .changed_o(changed_o), .recheck_o(recheck_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one update for a single edge; outputs are read half a cycle after it.
  task automatic do_op(input logic w, input logic s, input logic c,
                       input logic [63:0] d, input logic en);
    @(negedge clk);
    op_wr = w; op_set = s; op_clr = c; wr_data = d; irq_en = en;
    @(negedge clk);
    op_wr = 1'b0; op_set = 1'b0; op_clr = 1'b0; wr_data = '0; irq_en = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [31:0] p,
                            input logic ch, input logic rc);
    chk({req, " word"}, 64'(pend_o), 64'(p));
    chk({req, " changed"}, 64'(changed_o), 64'(ch));
    chk({req, " recheck"}, 64'(recheck_o), 64'(rc));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    expect_out("R1", 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_write;
    do_op(1, 0, 0, 64'hDEAD_BEEF_A5A5_0F0F, 1);
    expect_out("R4/R5/R7", 32'hA5A5_0F0F, 1'b1, 1'b1);
    @(negedge clk);
    expect_out("R9", 32'hA5A5_0F0F, 1'b0, 1'b0);
  endtask

  task automatic t_set;
    do_op(0, 1, 0, 64'h0000_0000_0000_00F0, 0);
    expect_out("R2/R7", 32'hA5A5_0FFF, 1'b1, 1'b0);
    do_op(0, 1, 0, 64'h0000_0000_0000_00F0, 1);
    expect_out("R6", 32'hA5A5_0FFF, 1'b0, 1'b0);
  endtask

  task automatic t_clear;
    do_op(0, 0, 1, 64'h0000_0000_A500_0000, 1);
    expect_out("R3", 32'h00A5_0FFF, 1'b1, 1'b1);
    do_op(0, 0, 1, 64'hFFFF_0000_FF00_0000, 1);
    expect_out("R6", 32'h00A5_0FFF, 1'b0, 1'b0);
  endtask

  task automatic t_upper;
    do_op(1, 0, 0, 64'hFFFF_FFFF_00A5_0FFF, 1);
    expect_out("R5", 32'h00A5_0FFF, 1'b0, 1'b0);
  endtask

  task automatic t_combo;
    do_op(1, 0, 1, 64'h0000_0000_0000_0001, 1);
    expect_out("R8 wr+clr", 32'h0, 1'b1, 1'b1);
    do_op(1, 1, 1, 64'h0000_0000_0000_0055, 1);
    expect_out("R8 all", 32'h0, 1'b0, 1'b0);
    do_op(1, 0, 0, 64'h0000_0000_0000_FFFF, 0);
    expect_out("R4", 32'h0000_FFFF, 1'b1, 1'b0);
    do_op(0, 1, 1, 64'h0000_0000_00FF_00F0, 1);
    expect_out("R8 set+clr", 32'h0000_FF0F, 1'b1, 1'b1);
    do_op(1, 1, 0, 64'h0000_0000_1234_0000, 1);
    expect_out("R8 wr+set", 32'h1234_0000, 1'b1, 1'b1);
    @(negedge clk);
    expect_out("R9", 32'h1234_0000, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_write();
    t_set();
    t_clear();
    t_upper();
    t_combo();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule